// File: doc/BRIEF.md
# Load/Store Alignment and Byte-Lane Steering Unit

This block sits between the load/store stage of a 64-bit core and a data memory that is eight byte lanes wide. Every access arrives with an address, a size code, a store flag, a signed-load flag and store data. The unit checks that the address is naturally aligned for the access size. A misaligned access raises a trap in the same cycle, and nothing reaches memory. A legal access goes to memory with the address rounded down to the 64-bit word, an 8-bit byte-enable mask, and store data moved onto the selected lanes.

An endian input picks the lane ordering. In little-endian mode, address offset k uses lane k, where lane k is bits 8k+7:8k of the memory word. In big-endian mode, offset k uses lane 7-k. In both modes the bytes of a value sit on a contiguous run of lanes, in their natural significance order. Load data returns from memory one cycle after the request. The unit keeps the lane position, size, extension mode and endian choice of that load, so it can extract the value and sign- or zero-extend it to 64 bits. The cycle after a trap, the unit reports the faulting address and size for one cycle.

Top module: `lsa_unit`

## Requirements
- R1: A byte access (size code 0) never traps, whatever its address.
- R2: A half-word access (size code 1) traps exactly when address bit 0 is 1.
- R3: A word access (size code 2, 32 bits) traps exactly when address bits 1:0 are not both zero.
- R4: A double access (size code 3, 64 bits) traps exactly when address bits 2:0 are not all zero.
- R5: While `trap_o` is high, `mem_req_o`, `mem_we_o` and every bit of `mem_be_o` are low.
- R6: In the cycle after a trap, `flt_valid_o` is 1 and `flt_addr_o`/`flt_size_o` hold the faulting address and size code. In the cycle after any cycle without a trap, `flt_valid_o` is 0.
- R7: A legal access drives `mem_req_o`=1 and `mem_addr_o` = the address with bits 2:0 cleared. `mem_be_o` has N=2^size consecutive bits set starting at lane L. L is the offset (address bits 2:0) in little-endian mode and 8-offset-N in big-endian mode, so a byte at offset 0 in big-endian mode uses lane 7 (`mem_be_o` = 8'h80).
- R8: A legal store drives `mem_we_o`=1. Its `mem_wdata_o` holds the low N bytes of `req_wdata_i` in lanes L..L+N-1 and zero in every other lane. A legal load drives `mem_we_o`=0.
- R9: When `mem_rvalid_i` is high in the cycle after a legal load request, `ld_valid_o`=1 and the low N bytes of `ld_data_o` are lanes L..L+N-1 of `mem_rdata_i`. After a store, a trap or an idle cycle, `ld_valid_o` stays 0.
- R10: When `req_signed_i` was 1 at the load request, bits above the loaded N bytes copy its top bit. When it was 0, they are zero.
- R11: Lane selection for returning load data uses the endian mode sampled at the request. A change of `big_endian_i` in the response cycle has no effect on `ld_data_o`.
- R12: While reset is asserted, `mem_req_o`, `mem_we_o`, `mem_be_o`, `ld_valid_o`, `trap_o` (with no request) and `flt_valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Access request present |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| req_signed_i | input | 1 | Load sign-extends when 1 |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 64 | Store value, right-justified |
| big_endian_i | input | 1 | Endian mode: 1 = offset 0 on lane 7 |
| mem_req_o | output | 1 | Memory access issued |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_be_o | output | 8 | Byte-lane enables |
| mem_wdata_o | output | 64 | Lane-steered store data |
| mem_rvalid_i | input | 1 | Read data present (one cycle after request) |
| mem_rdata_i | input | 64 | Memory read word |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 64 | Extracted and extended load value |
| trap_o | output | 1 | Misaligned access, same cycle |
| flt_valid_o | output | 1 | Fault report valid |
| flt_addr_o | output | ADDR_W | Faulting address |
| flt_size_o | output | 2 | Faulting size code |

## Verification
The bench builds the unit with its default 32-bit address width. Random addresses therefore cover the full range of upper bits, which the word rounding and the captured fault address must carry through unchanged. Every offset and size combination is reachable in both endian modes, so each lane base from 0 to 7 and every mask shape appears. In the response cycle the endian input is toggled at random, which puts the captured mode to the test.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int LANES  = 8;
  localparam int DATA_W = LANES * 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic [OFF_W-1:0] lane;
    acc_size_e        size;
    logic             sext;
  } ld_ctx_t;
endpackage

// File: rtl/lsa_align_chk.sv
module lsa_align_chk
  import lsa_pkg::*;
(
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  output logic             misal_o
);
  logic [OFF_W-1:0] low_mask;

  always_comb begin
    unique case (size_i)
      SZ_B:    low_mask = OFF_W'(0);
      SZ_H:    low_mask = OFF_W'(1);
      SZ_W:    low_mask = OFF_W'(3);
      default: low_mask = OFF_W'(7);
    endcase
    misal_o = |(off_i & low_mask);
  end
endmodule

// File: rtl/lsa_lane_map.sv
module lsa_lane_map
  import lsa_pkg::*;
(
  input  acc_size_e        size_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             big_i,
  output logic [OFF_W-1:0] lane_o,
  output logic [LANES-1:0] be_o
);
  logic [OFF_W:0] nbytes;
  logic [OFF_W:0] base_w;
  logic [OFF_W:0] top_w;

  always_comb begin
    nbytes = (OFF_W+1)'(1) << size_i;
    if (big_i) base_w = (OFF_W+1)'(LANES) - {1'b0, off_i} - nbytes;
    else       base_w = {1'b0, off_i};
    top_w  = base_w + nbytes;
    lane_o = base_w[OFF_W-1:0];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_be
    assign be_o[i] = (base_w <= (OFF_W+1)'(i)) && ((OFF_W+1)'(i) < top_w);
  end
endmodule

// File: rtl/lsa_load_ext.sv
module lsa_load_ext
  import lsa_pkg::*;
(
  input  logic [DATA_W-1:0] rdata_i,
  input  ld_ctx_t           ctx_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] sh;

  always_comb begin
    sh = rdata_i >> {ctx_i.lane, 3'b000};
    unique case (ctx_i.size)
      SZ_B:    data_o = {{(DATA_W-8){ctx_i.sext & sh[7]}},   sh[7:0]};
      SZ_H:    data_o = {{(DATA_W-16){ctx_i.sext & sh[15]}}, sh[15:0]};
      SZ_W:    data_o = {{(DATA_W-32){ctx_i.sext & sh[31]}}, sh[31:0]};
      default: data_o = sh;
    endcase
  end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [1:0]        req_size_i,
  input  logic              req_signed_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [63:0]       req_wdata_i,
  input  logic              big_endian_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_be_o,
  output logic [63:0]       mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [63:0]       mem_rdata_i,
  output logic              ld_valid_o,
  output logic [63:0]       ld_data_o,
  output logic              trap_o,
  output logic              flt_valid_o,
  output logic [ADDR_W-1:0] flt_addr_o,
  output logic [1:0]        flt_size_o
);
  acc_size_e         size;
  logic [OFF_W-1:0]  off;
  logic              misal;
  logic              issue;
  logic [OFF_W-1:0]  lane;
  logic [LANES-1:0]  be;
  logic [DATA_W-1:0] smask;

  ld_ctx_t           ctx_q, ctx_d;
  logic              ctx_vld_q, ctx_vld_d, ctx_en;
  logic              flt_vld_q, flt_vld_d, flt_en;
  logic [ADDR_W-1:0] flt_addr_q, flt_addr_d;
  logic [1:0]        flt_size_q, flt_size_d;

  assign size = acc_size_e'(req_size_i);
  assign off  = req_addr_i[OFF_W-1:0];

  lsa_align_chk u_align (
    .size_i (size),
    .off_i  (off),
    .misal_o(misal)
  );

  lsa_lane_map u_map (
    .size_i(size),
    .off_i (off),
    .big_i (big_endian_i),
    .lane_o(lane),
    .be_o  (be)
  );

  lsa_load_ext u_ext (
    .rdata_i(mem_rdata_i),
    .ctx_i  (ctx_q),
    .data_o (ld_data_o)
  );

  // request path
  always_comb begin
    unique case (size)
      SZ_B:    smask = DATA_W'(64'h0000_0000_0000_00FF);
      SZ_H:    smask = DATA_W'(64'h0000_0000_0000_FFFF);
      SZ_W:    smask = DATA_W'(64'h0000_0000_FFFF_FFFF);
      default: smask = '1;
    endcase
    trap_o      = req_valid_i & misal;
    issue       = req_valid_i & ~misal;
    mem_req_o   = issue;
    mem_we_o    = issue & req_store_i;
    mem_addr_o  = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    mem_be_o    = issue ? be : '0;
    mem_wdata_o = (issue & req_store_i) ? ((req_wdata_i & smask) << {lane, 3'b000}) : '0;
  end

  // next state
  always_comb begin
    ctx_en     = issue & ~req_store_i;
    flt_en     = trap_o;
    ctx_vld_d  = ctx_en;
    flt_vld_d  = trap_o;
    ctx_d      = '{lane: lane, size: size, sext: req_signed_i};
    flt_addr_d = req_addr_i;
    flt_size_d = req_size_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctx_vld_q  <= 1'b0;
      flt_vld_q  <= 1'b0;
      ctx_q      <= '{lane: '0, size: SZ_B, sext: 1'b0};
      flt_addr_q <= '0;
      flt_size_q <= '0;
    end else begin
      ctx_vld_q <= ctx_vld_d;
      flt_vld_q <= flt_vld_d;
      if (ctx_en) ctx_q <= ctx_d;
      if (flt_en) begin
        flt_addr_q <= flt_addr_d;
        flt_size_q <= flt_size_d;
      end
    end
  end

  assign ld_valid_o  = ctx_vld_q & mem_rvalid_i;
  assign flt_valid_o = flt_vld_q;
  assign flt_addr_o  = flt_addr_q;
  assign flt_size_o  = flt_size_q;
endmodule

// File: rtl/lsa_unit_chk.sv
module lsa_unit_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic              req_store_i,
  input logic [1:0]        req_size_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [7:0]        mem_be_o,
  input logic              ld_valid_o,
  input logic              trap_o,
  input logic              flt_valid_o,
  input logic [ADDR_W-1:0] flt_addr_o,
  input logic [1:0]        flt_size_o
);
  a_r1_byte_never_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_size_i == 2'd0) |-> !trap_o);

  a_r4_double_offset_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_size_i == 2'd3 && req_addr_i[2:0] != 3'd0) |-> trap_o);

  a_r5_trap_blocks_memory: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |-> (!mem_req_o && !mem_we_o && mem_be_o == 8'h00));

  a_r6_fault_reported: assert property (@(posedge clk) disable iff (!rst_n)
    trap_o |=> (flt_valid_o && flt_addr_o == $past(req_addr_i) && flt_size_o == $past(req_size_i)));

  a_r6_no_spurious_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_o |=> !flt_valid_o);

  a_r7_enable_count: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> ($countones(mem_be_o) == (1 << req_size_i)));

  a_r8_load_never_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !req_store_i) |-> !mem_we_o);

  a_r9_result_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |-> $past(mem_req_o && !mem_we_o));
endmodule

bind lsa_unit lsa_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid_i(req_valid_i),
  .req_store_i(req_store_i),
  .req_size_i (req_size_i),
  .req_addr_i (req_addr_i),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_be_o   (mem_be_o),
  .ld_valid_o (ld_valid_o),
  .trap_o     (trap_o),
  .flt_valid_o(flt_valid_o),
  .flt_addr_o (flt_addr_o),
  .flt_size_o (flt_size_o)
);

// File: tb/lsa_unit_bench.sv
module lsa_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid_i, req_store_i, req_signed_i, big_endian_i;
  logic [1:0]    req_size_i;
  logic [AW-1:0] req_addr_i;
  logic [63:0]   req_wdata_i;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [7:0]    mem_be_o;
  logic [63:0]   mem_wdata_o;
  logic          mem_rvalid_i;
  logic [63:0]   mem_rdata_i;
  logic          ld_valid_o;
  logic [63:0]   ld_data_o;
  logic          trap_o, flt_valid_o;
  logic [AW-1:0] flt_addr_o;
  logic [1:0]    flt_size_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsa_unit #(.ADDR_W(AW)) u_lsa_unit (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_store_i(req_store_i), .req_size_i(req_size_i),
    .req_signed_i(req_signed_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .big_endian_i(big_endian_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .ld_valid_o(ld_valid_o), .ld_data_o(ld_data_o),
    .trap_o(trap_o), .flt_valid_o(flt_valid_o), .flt_addr_o(flt_addr_o),
    .flt_size_o(flt_size_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [1:0] sz);
    return 1 << sz;
  endfunction

  function automatic int lane_of(input logic [2:0] off, input logic [1:0] sz, input bit big);
    return big ? (8 - int'(off) - nbytes(sz)) : int'(off);
  endfunction

  function automatic logic [7:0] exp_be(input logic [2:0] off, input logic [1:0] sz, input bit big);
    logic [7:0] m = 8'h00;
    for (int k = 0; k < nbytes(sz); k++) m[lane_of(off, sz, big) + k] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] exp_wd(input logic [63:0] d, input logic [2:0] off,
                                         input logic [1:0] sz, input bit big);
    logic [63:0] w = '0;
    int l = lane_of(off, sz, big);
    for (int k = 0; k < nbytes(sz); k++) w[8*(l+k) +: 8] = d[8*k +: 8];
    return w;
  endfunction

  function automatic logic [63:0] exp_ld(input logic [63:0] rd, input logic [2:0] off,
                                         input logic [1:0] sz, input bit big, input bit sg);
    logic [63:0] v = '0;
    int l = lane_of(off, sz, big);
    bit top;
    for (int k = 0; k < nbytes(sz); k++) v[8*k +: 8] = rd[8*(l+k) +: 8];
    top = v[8*nbytes(sz) - 1];
    for (int b = 8*nbytes(sz); b < 64; b++) v[b] = sg & top;
    return v;
  endfunction

  function automatic string size_tag(input logic [1:0] sz);
    case (sz)
      2'd0:    return "R1";
      2'd1:    return "R2";
      2'd2:    return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic access(input bit st, input logic [1:0] sz, input bit sg, input logic [AW-1:0] a,
                        input logic [63:0] wd, input bit big, input logic [63:0] rd, input bit flip);
    bit bad = (int'(a[2:0]) % nbytes(sz)) != 0;
    @(negedge clk);
    req_valid_i = 1'b1; req_store_i = st; req_size_i = sz; req_signed_i = sg;
    req_addr_i = a; req_wdata_i = wd; big_endian_i = big; mem_rvalid_i = 1'b0;
    #1;
    chk(trap_o == bad, size_tag(sz), 64'(trap_o), 64'(bad));
    if (bad) begin
      chk(!mem_req_o && !mem_we_o && mem_be_o == 8'h00, "R5",
          {55'd0, mem_req_o, mem_be_o}, 64'd0);
    end else begin
      chk(mem_req_o && mem_addr_o == {a[AW-1:3], 3'b000}, "R7 addr",
          64'(mem_addr_o), 64'({a[AW-1:3], 3'b000}));
      chk(mem_be_o == exp_be(a[2:0], sz, big), "R7 be", 64'(mem_be_o), 64'(exp_be(a[2:0], sz, big)));
      chk(mem_we_o == st, "R8 we", 64'(mem_we_o), 64'(st));
      if (st) chk(mem_wdata_o == exp_wd(wd, a[2:0], sz, big), "R8 wdata",
                  mem_wdata_o, exp_wd(wd, a[2:0], sz, big));
    end
    @(negedge clk);
    req_valid_i = 1'b0;
    mem_rvalid_i = 1'b1; mem_rdata_i = rd;
    if (flip) big_endian_i = ~big;
    #1;
    chk(flt_valid_o == bad, "R6 valid", 64'(flt_valid_o), 64'(bad));
    if (bad) chk(flt_addr_o == a && flt_size_o == sz, "R6 payload",
                 {30'd0, flt_size_o, flt_addr_o}, {30'd0, sz, a});
    if (!bad && !st) begin
      chk(ld_valid_o == 1'b1, "R9 valid", 64'(ld_valid_o), 64'd1);
      chk(ld_data_o == exp_ld(rd, a[2:0], sz, big, sg), flip ? "R11 data" : (sg ? "R10 data" : "R9 data"),
          ld_data_o, exp_ld(rd, a[2:0], sz, big, sg));
    end else begin
      chk(ld_valid_o == 1'b0, "R9 no result", 64'(ld_valid_o), 64'd0);
    end
    @(negedge clk);
    mem_rvalid_i = 1'b0;
    #1;
    chk(flt_valid_o == 1'b0, "R6 clear", 64'(flt_valid_o), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid_i = 1'b0; req_store_i = 1'b0; req_size_i = 2'd0; req_signed_i = 1'b0;
    req_addr_i = '0; req_wdata_i = '0; big_endian_i = 1'b0;
    mem_rvalid_i = 1'b1; mem_rdata_i = 64'hFFFF_FFFF_FFFF_FFFF;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1;
    chk(!mem_req_o && !mem_we_o && mem_be_o == 8'h00 && !ld_valid_o && !trap_o && !flt_valid_o,
        "R12 reset", {58'd0, mem_req_o, mem_we_o, ld_valid_o, trap_o, flt_valid_o, |mem_be_o}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1; mem_rvalid_i = 1'b0;
    @(negedge clk);

    // directed corners
    access(1'b1, 2'd0, 1'b0, 32'h0000_1000, 64'hAB, 1'b1, '0, 1'b0);                 // R7 lane 7
    access(1'b1, 2'd0, 1'b0, 32'h0000_1007, 64'hCD, 1'b0, '0, 1'b0);                 // R1 odd offset
    access(1'b1, 2'd1, 1'b0, 32'h0000_2002, 64'h1234, 1'b1, '0, 1'b0);               // R7 lanes 4,5
    access(1'b0, 2'd1, 1'b0, 32'h0000_2003, '0, 1'b0, '0, 1'b0);                     // R2 trap
    access(1'b1, 2'd2, 1'b0, 32'h0000_3002, 64'h1, 1'b0, '0, 1'b0);                  // R3 trap
    access(1'b1, 2'd3, 1'b0, 32'hFFFF_FFF4, 64'h1, 1'b1, '0, 1'b0);                  // R4 trap
    access(1'b0, 2'd3, 1'b0, 32'h8000_0008, '0, 1'b1, 64'h0123_4567_89AB_CDEF, 1'b0);
    access(1'b0, 2'd0, 1'b1, 32'h0000_0005, '0, 1'b0, 64'h0000_8000_0000_0000, 1'b0); // R10 sign
    access(1'b0, 2'd0, 1'b0, 32'h0000_0005, '0, 1'b0, 64'h0000_8000_0000_0000, 1'b0); // R10 zero
    access(1'b0, 2'd2, 1'b1, 32'h0000_0004, '0, 1'b1, 64'h0000_0000_8765_4321, 1'b1); // R11 flip
    access(1'b0, 2'd1, 1'b1, 32'h0000_0006, '0, 1'b0, 64'hFEDC_0000_0000_0000, 1'b1); // R11 flip

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [AW-1:0] a = $urandom;
      logic [1:0] sz = 2'($urandom_range(3));
      if ($urandom_range(3) != 0) a[2:0] = a[2:0] & ~3'(nbytes(sz) - 1);
      access(1'($urandom_range(1)), sz, 1'($urandom_range(1)), a,
             {$urandom, $urandom}, 1'($urandom_range(1)), {$urandom, $urandom},
             1'($urandom_range(1)));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule